// File: doc/BRIEF.md
# Virtual Interrupt End-of-Interrupt Handler

This block handles an end-of-interrupt write that a guest makes to a virtual interrupt CPU interface. It accepts one strobe carrying the written interrupt ID and latches it. It also latches the guest's current interrupt group, the split-mode bit and the group's preemption shift. It then asks an external priority-drop unit to drop the highest active priority and waits for the dropped priority value to come back. The drop happens whatever the rest of the operation decides.

After the drop, the block decides whether the interrupt can be deactivated. Message-signalled IDs and split-mode writes stop at the drop. Otherwise the in-use list registers are read one per cycle, starting from index 0, through a single read port. The first active entry whose virtual ID equals the written ID is selected. If that entry's group and reduced priority both agree, its active bit is cleared through the write port. If the entry is hardware-backed, a physical deactivate request is issued in the same cycle. When no entry matches, the missed-EOI counter field of the hypervisor control word is incremented through a read-modify-write. A one-cycle done pulse closes every operation.

Top module: `veoi_eoi_unit`

List-register layout (LR_W = 38 bits with default parameters): virtual ID [15:0], physical ID [25:16], priority [33:26], group bit 34, hardware bit 35, active bit 36, pending bit 37.

## Requirements
- R1: Out of reset, done, drop_req, lr_wr_en, hcr_wr_en and dir_valid are all low.
- R2: Each accepted EOI raises drop_req until drop_ack, exactly once, and no list-register or control-word write occurs before that handshake.
- R3: A written ID of 8192 or above completes after the drop with no list-register write, no control-word write and no deactivate request.
- R4: With split_mode high at acceptance, the operation completes after the drop with no list-register write, no control-word write and no deactivate request, even when an entry matches.
- R5: Entries are examined from index 0 upward, only below min(used_lrs, NUM_LR). The first entry with virtual ID [15:0] equal to the written ID and active bit 36 set is selected. Inactive entries and entries at or above the used count are never selected.
- R6: When no entry is selected, one control-word write is made. It has bits [31:27] equal to the read value plus one modulo 32 and every other bit unchanged.
- R7: If the selected entry's group bit 34 differs from cur_grp, no list-register write and no deactivate request occur.
- R8: The entry priority [33:26], with its lowest prio_shift bits forced to zero, is compared with drop_prio. On inequality nothing is written. On equality the deactivation proceeds.
- R9: On a valid selection, exactly one write goes to the selected index, with bit 36 cleared and all other bits as read.
- R10: A valid selection whose hardware bit 35 is set issues one dir_valid pulse carrying bits [25:16] in the cycle of the list-register write. With bit 35 clear, no request is issued.
- R11: done pulses for one cycle, in the cycle after the last write or handshake. eoi_valid strobes that arrive before done are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| eoi_valid | input | 1 | EOI write strobe, taken only when idle |
| eoi_id | input | ID_W | Written interrupt ID |
| cur_grp | input | 1 | Group of the EOI register written |
| split_mode | input | 1 | Split drop/deactivate mode |
| prio_shift | input | SH_W | Low priority bits below the preemption level |
| used_lrs | input | UC_W | Number of list registers in use |
| drop_req | output | 1 | Priority-drop request |
| drop_ack | input | 1 | Priority-drop completion |
| drop_prio | input | PRIO_W | Priority that was dropped |
| lr_rd_idx | output | IDX_W | List-register read index |
| lr_rd_data | input | LR_W | List-register read data, same cycle |
| lr_wr_en | output | 1 | List-register write strobe |
| lr_wr_idx | output | IDX_W | List-register write index |
| lr_wr_data | output | LR_W | List-register write data |
| hcr_rd_data | input | CTRL_W | Current control word |
| hcr_wr_en | output | 1 | Control-word write strobe |
| hcr_wr_data | output | CTRL_W | Control word with counter bumped |
| dir_valid | output | 1 | Physical deactivate request |
| dir_pid | output | PID_W | Physical ID to deactivate |
| done | output | 1 | Operation complete pulse |

## Verification
Each run is stimulated so that it lands on a single path, and each path is told apart by which of the write, deactivate and counter strobes appear.

- The message-ID and split-mode runs use a list register that would otherwise match, so any leak past the drop shows up as a write.
- Two matching active entries plus a matching inactive one at index 0 separate first-match order from last-match order and from ignoring the active bit.
- A match placed just above the used count separates a bounded search from a full one.
- Priority pairs that differ only in masked bits, and pairs that differ above the mask, separate correct reduction from raw comparison.
- Counter runs start from 31 with non-zero neighbouring bits, to expose a carry into bits outside the field.

// File: rtl/veoi_pkg.sv
package veoi_pkg;
   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_DROP = 3'd1,
      ST_SCAN = 3'd2,
      ST_ACT  = 3'd3,
      ST_MISS = 3'd4,
      ST_FIN  = 3'd5
   } veoi_state_e;
endpackage

// File: rtl/veoi_prio_mask.sv
module veoi_prio_mask #(
   parameter int PRIO_W = 8,
   localparam int SH_W  = (PRIO_W > 1) ? $clog2(PRIO_W) : 1
) (
   input  logic [PRIO_W-1:0] prio_in,
   input  logic [SH_W-1:0]   shift,
   output logic [PRIO_W-1:0] prio_out
);
   for (genvar b = 0; b < PRIO_W; b++) begin : g_bit
      assign prio_out[b] = prio_in[b] & (b >= int'(shift));
   end
endmodule

// File: rtl/veoi_lr_probe.sv
module veoi_lr_probe #(
   parameter int ID_W   = 16,
   parameter int PID_W  = 10,
   parameter int PRIO_W = 8,
   localparam int SH_W    = (PRIO_W > 1) ? $clog2(PRIO_W) : 1,
   localparam int PID_LSB = ID_W,
   localparam int PRI_LSB = ID_W + PID_W,
   localparam int GRP_B   = PRI_LSB + PRIO_W,
   localparam int HW_B    = GRP_B + 1,
   localparam int ACT_B   = GRP_B + 2,
   localparam int LR_W    = GRP_B + 4
) (
   input  logic [LR_W-1:0]   entry,
   input  logic [ID_W-1:0]   tgt_id,
   input  logic              grp,
   input  logic [PRIO_W-1:0] drop_prio,
   input  logic [SH_W-1:0]   shift,
   output logic              hit,
   output logic              grp_ok,
   output logic              prio_ok,
   output logic              hw,
   output logic [PID_W-1:0]  pid,
   output logic [LR_W-1:0]   cleared
);
   logic [PRIO_W-1:0] red_prio;

   veoi_prio_mask #(.PRIO_W(PRIO_W)) i_mask (
      .prio_in  (entry[PRI_LSB +: PRIO_W]),
      .shift    (shift),
      .prio_out (red_prio)
   );

   always_comb begin
      hit     = entry[ACT_B] && (entry[ID_W-1:0] == tgt_id);
      grp_ok  = (entry[GRP_B] == grp);
      prio_ok = (red_prio == drop_prio);
      hw      = entry[HW_B];
      pid     = entry[PID_LSB +: PID_W];
      cleared = entry;
      cleared[ACT_B] = 1'b0;
   end
endmodule

// File: rtl/veoi_cnt_bump.sv
module veoi_cnt_bump #(
   parameter int CTRL_W  = 32,
   parameter int CNT_LSB = 27,
   parameter int CNT_W   = 5
) (
   input  logic [CTRL_W-1:0] word_in,
   output logic [CTRL_W-1:0] word_out
);
   logic [CNT_W-1:0] cnt_nxt;

   always_comb begin
      cnt_nxt  = word_in[CNT_LSB +: CNT_W] + CNT_W'(1);
      word_out = word_in;
      word_out[CNT_LSB +: CNT_W] = cnt_nxt;
   end
endmodule

// File: rtl/veoi_eoi_unit.sv
module veoi_eoi_unit #(
   parameter int NUM_LR   = 8,
   parameter int ID_W     = 16,
   parameter int PID_W    = 10,
   parameter int PRIO_W   = 8,
   parameter int LPI_BASE = 8192,
   parameter int CTRL_W   = 32,
   parameter int CNT_LSB  = 27,
   parameter int CNT_W    = 5,
   localparam int IDX_W = $clog2(NUM_LR),
   localparam int UC_W  = $clog2(NUM_LR + 1),
   localparam int SH_W  = (PRIO_W > 1) ? $clog2(PRIO_W) : 1,
   localparam int LR_W  = ID_W + PID_W + PRIO_W + 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              eoi_valid,
   input  logic [ID_W-1:0]   eoi_id,
   input  logic              cur_grp,
   input  logic              split_mode,
   input  logic [SH_W-1:0]   prio_shift,
   input  logic [UC_W-1:0]   used_lrs,
   output logic              drop_req,
   input  logic              drop_ack,
   input  logic [PRIO_W-1:0] drop_prio,
   output logic [IDX_W-1:0]  lr_rd_idx,
   input  logic [LR_W-1:0]   lr_rd_data,
   output logic              lr_wr_en,
   output logic [IDX_W-1:0]  lr_wr_idx,
   output logic [LR_W-1:0]   lr_wr_data,
   input  logic [CTRL_W-1:0] hcr_rd_data,
   output logic              hcr_wr_en,
   output logic [CTRL_W-1:0] hcr_wr_data,
   output logic              dir_valid,
   output logic [PID_W-1:0]  dir_pid,
   output logic              done
);
   import veoi_pkg::*;

   localparam int ACT_B = ID_W + PID_W + PRIO_W + 2;

   if (NUM_LR < 4 || NUM_LR > 16) begin : g_bad_lr
      $error("NUM_LR must lie in 4..16");
   end
   if (LPI_BASE >= (1 << ID_W)) begin : g_bad_lpi
      $error("LPI_BASE must be representable in ID_W bits");
   end
   if (CNT_LSB + CNT_W > CTRL_W) begin : g_bad_cnt
      $error("counter field exceeds control word");
   end
   if (PRIO_W < 2) begin : g_bad_prio
      $error("PRIO_W must be at least 2");
   end

   veoi_state_e       st_q;
   logic [ID_W-1:0]   id_q;
   logic              grp_q;
   logic              split_q;
   logic [SH_W-1:0]   shift_q;
   logic [UC_W-1:0]   used_q;
   logic [PRIO_W-1:0] dprio_q;
   logic [UC_W-1:0]   scan_q;
   logic              dropped_q;
   logic [LR_W-1:0]   clr_q;
   logic              ok_q;
   logic              hw_q;
   logic [PID_W-1:0]  pid_q;

   logic              p_hit;
   logic              p_grp_ok;
   logic              p_prio_ok;
   logic              p_hw;
   logic [PID_W-1:0]  p_pid;
   logic [LR_W-1:0]   p_clr;
   logic              skip_deact;
   logic              scan_end;

   veoi_lr_probe #(
      .ID_W   (ID_W),
      .PID_W  (PID_W),
      .PRIO_W (PRIO_W)
   ) i_probe (
      .entry     (lr_rd_data),
      .tgt_id    (id_q),
      .grp       (grp_q),
      .drop_prio (dprio_q),
      .shift     (shift_q),
      .hit       (p_hit),
      .grp_ok    (p_grp_ok),
      .prio_ok   (p_prio_ok),
      .hw        (p_hw),
      .pid       (p_pid),
      .cleared   (p_clr)
   );

   veoi_cnt_bump #(
      .CTRL_W  (CTRL_W),
      .CNT_LSB (CNT_LSB),
      .CNT_W   (CNT_W)
   ) i_bump (
      .word_in  (hcr_rd_data),
      .word_out (hcr_wr_data)
   );

   always_comb begin
      skip_deact = (id_q >= ID_W'(LPI_BASE)) || split_q;
      scan_end   = (scan_q >= used_q);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= ST_IDLE;
         id_q      <= '0;
         grp_q     <= 1'b0;
         split_q   <= 1'b0;
         shift_q   <= '0;
         used_q    <= '0;
         dprio_q   <= '0;
         scan_q    <= '0;
         dropped_q <= 1'b0;
         clr_q     <= '0;
         ok_q      <= 1'b0;
         hw_q      <= 1'b0;
         pid_q     <= '0;
      end else begin
         unique case (st_q)
            ST_IDLE: begin
               if (eoi_valid) begin
                  id_q      <= eoi_id;
                  grp_q     <= cur_grp;
                  split_q   <= split_mode;
                  shift_q   <= prio_shift;
                  used_q    <= (used_lrs > UC_W'(NUM_LR)) ? UC_W'(NUM_LR) : used_lrs;
                  dropped_q <= 1'b0;
                  st_q      <= ST_DROP;
               end
            end
            ST_DROP: begin
               if (drop_ack) begin
                  dprio_q   <= drop_prio;
                  dropped_q <= 1'b1;
                  scan_q    <= '0;
                  st_q      <= skip_deact ? ST_FIN : ST_SCAN;
               end
            end
            ST_SCAN: begin
               if (scan_end) begin
                  st_q <= ST_MISS;
               end else if (p_hit) begin
                  clr_q <= p_clr;
                  ok_q  <= p_grp_ok && p_prio_ok;
                  hw_q  <= p_hw;
                  pid_q <= p_pid;
                  st_q  <= ST_ACT;
               end else begin
                  scan_q <= scan_q + UC_W'(1);
               end
            end
            ST_ACT:  st_q <= ST_FIN;
            ST_MISS: st_q <= ST_FIN;
            ST_FIN:  st_q <= ST_IDLE;
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      drop_req   = (st_q == ST_DROP);
      lr_rd_idx  = scan_q[IDX_W-1:0];
      lr_wr_en   = (st_q == ST_ACT) && ok_q;
      lr_wr_idx  = scan_q[IDX_W-1:0];
      lr_wr_data = clr_q;
      dir_valid  = (st_q == ST_ACT) && ok_q && hw_q;
      dir_pid    = pid_q;
      hcr_wr_en  = (st_q == ST_MISS);
      done       = (st_q == ST_FIN);
   end

   AST_WR_AFTER_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (lr_wr_en || hcr_wr_en) |-> dropped_q); // R2
   AST_NO_DEACT_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
      lr_wr_en |-> ((id_q < ID_W'(LPI_BASE)) && !split_q)); // R3
   AST_SPLIT_NO_CNT: assert property (@(posedge clk) disable iff (!rst_n)
      hcr_wr_en |-> !split_q); // R4
   AST_IDX_IN_USE: assert property (@(posedge clk) disable iff (!rst_n)
      lr_wr_en |-> (UC_W'(lr_wr_idx) < used_q)); // R5
   AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      hcr_wr_en |-> (hcr_wr_data[CNT_LSB +: CNT_W] ==
                     hcr_rd_data[CNT_LSB +: CNT_W] + CNT_W'(1))); // R6
   AST_WR_CLEARS_ACT: assert property (@(posedge clk) disable iff (!rst_n)
      lr_wr_en |-> !lr_wr_data[ACT_B]); // R9
   AST_DIR_WITH_WR: assert property (@(posedge clk) disable iff (!rst_n)
      dir_valid |-> lr_wr_en); // R10
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R11
   AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q != ST_IDLE) |=> $stable(id_q)); // R11
endmodule

// File: tb/test_veoi_eoi_unit.sv
module test_veoi_eoi_unit;
   localparam int NUM_LR = 8;
   localparam int LR_W   = 38;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        eoi_valid = 1'b0;
   logic [15:0] eoi_id = '0;
   logic        cur_grp = 1'b0;
   logic        split_mode = 1'b0;
   logic [2:0]  prio_shift = '0;
   logic [3:0]  used_lrs = '0;
   logic        drop_req;
   logic        drop_ack = 1'b0;
   logic [7:0]  drop_prio = '0;
   logic [2:0]  lr_rd_idx;
   logic [LR_W-1:0] lr_rd_data;
   logic        lr_wr_en;
   logic [2:0]  lr_wr_idx;
   logic [LR_W-1:0] lr_wr_data;
   logic [31:0] hcr_reg = '0;
   logic        hcr_wr_en;
   logic [31:0] hcr_wr_data;
   logic        dir_valid;
   logic [9:0]  dir_pid;
   logic        done;

   logic [LR_W-1:0] lrs [NUM_LR];

   always #2.5 clk = ~clk;

   veoi_eoi_unit i_veoi_eoi_unit (
      .clk(clk), .rst_n(rst_n), .eoi_valid(eoi_valid), .eoi_id(eoi_id),
      .cur_grp(cur_grp), .split_mode(split_mode), .prio_shift(prio_shift),
      .used_lrs(used_lrs), .drop_req(drop_req), .drop_ack(drop_ack),
      .drop_prio(drop_prio), .lr_rd_idx(lr_rd_idx), .lr_rd_data(lr_rd_data),
      .lr_wr_en(lr_wr_en), .lr_wr_idx(lr_wr_idx), .lr_wr_data(lr_wr_data),
      .hcr_rd_data(hcr_reg), .hcr_wr_en(hcr_wr_en), .hcr_wr_data(hcr_wr_data),
      .dir_valid(dir_valid), .dir_pid(dir_pid), .done(done)
   );

   assign lr_rd_data = lrs[lr_rd_idx];

   always @(posedge clk) begin
      drop_ack <= drop_req & ~drop_ack;
      if (lr_wr_en) lrs[lr_wr_idx] <= lr_wr_data;
      if (hcr_wr_en) hcr_reg <= hcr_wr_data;
   end

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int n_drop, n_lrw, n_hcrw, n_dir, n_done, act_cyc, done_cyc;
   logic [2:0]      w_idx;
   logic [LR_W-1:0] w_data;
   logic [9:0]      d_pid;

   always @(negedge clk) begin
      if (drop_req && drop_ack) begin n_drop++; act_cyc = cyc; end
      if (lr_wr_en) begin n_lrw++; w_idx = lr_wr_idx; w_data = lr_wr_data; act_cyc = cyc; end
      if (hcr_wr_en) begin n_hcrw++; act_cyc = cyc; end
      if (dir_valid) begin n_dir++; d_pid = dir_pid; end
      if (done) begin n_done++; done_cyc = cyc; end
   end

   int n_chk = 0;
   int n_fail = 0;

   task automatic chk(input bit ok, input string tag, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
      end
   endtask

   function automatic logic [LR_W-1:0] mk_lr(input logic [15:0] vid, input logic [9:0] pid,
      input logic [7:0] pri, input bit grp, input bit hw, input bit act);
      return {1'b0, act, hw, grp, pri, pid, vid};
   endfunction

   localparam logic [LR_W-1:0] ACT_MASK = LR_W'(1) << 36;

   task automatic clear_lrs();
      for (int i = 0; i < NUM_LR; i++) lrs[i] = '0;
   endtask

   task automatic run_eoi(input logic [15:0] id, input bit grp, input bit split,
      input logic [2:0] sh, input logic [3:0] used, input logic [7:0] dp, input bit poke);
      n_drop = 0; n_lrw = 0; n_hcrw = 0; n_dir = 0; n_done = 0;
      act_cyc = -100; done_cyc = -200;
      @(negedge clk);
      eoi_id = id; cur_grp = grp; split_mode = split; prio_shift = sh;
      used_lrs = used; drop_prio = dp; eoi_valid = 1'b1;
      @(negedge clk);
      eoi_valid = 1'b0;
      if (poke) begin
         @(negedge clk);
         eoi_id = 16'h0009; eoi_valid = 1'b1;
         @(negedge clk);
         eoi_valid = 1'b0;
      end
      for (int k = 0; k < 100 && n_done == 0; k++) @(negedge clk);
      repeat (3) @(negedge clk);
      chk(n_drop == 1, "R2", "drop handshakes", n_drop, 1);
      chk(n_done == 1, "R11", "done pulses", n_done, 1);
   endtask

   task automatic t_reset();
      chk(!done && !drop_req && !lr_wr_en && !hcr_wr_en && !dir_valid, "R1",
          "idle outputs", {done, drop_req, lr_wr_en, hcr_wr_en, dir_valid}, 0);
   endtask

   task automatic t_lpi();
      clear_lrs();
      lrs[0] = mk_lr(16'd8200, 10'd1, 8'h40, 1'b1, 1'b1, 1'b1);
      hcr_reg = 32'h0000_00AA;
      run_eoi(16'd8200, 1'b1, 1'b0, 3'd0, 4'd4, 8'h40, 1'b0);
      chk(n_lrw == 0 && n_dir == 0 && n_hcrw == 0, "R3", "writes for LPI",
          n_lrw + n_dir + n_hcrw, 0);
      chk(done_cyc == act_cyc + 1, "R11", "done after drop", done_cyc, act_cyc + 1);
   endtask

   task automatic t_split();
      clear_lrs();
      lrs[0] = mk_lr(16'd33, 10'd2, 8'h40, 1'b1, 1'b1, 1'b1);
      run_eoi(16'd33, 1'b1, 1'b1, 3'd0, 4'd4, 8'h40, 1'b0);
      chk(n_lrw == 0 && n_dir == 0 && n_hcrw == 0, "R4", "writes in split mode",
          n_lrw + n_dir + n_hcrw, 0);
      chk(lrs[0][36] == 1'b1, "R4", "entry still active", lrs[0][36], 1);
   endtask

   task automatic t_match_basic();
      logic [LR_W-1:0] e;
      clear_lrs();
      e = mk_lr(16'd45, 10'h0AB, 8'h40, 1'b1, 1'b0, 1'b1);
      lrs[2] = e;
      run_eoi(16'd45, 1'b1, 1'b0, 3'd0, 4'd4, 8'h40, 1'b0);
      chk(n_lrw == 1, "R9", "write count", n_lrw, 1);
      chk(w_idx == 3'd2, "R9", "write index", w_idx, 2);
      chk(w_data == (e & ~ACT_MASK), "R9", "write data", w_data, e & ~ACT_MASK);
      chk(n_dir == 0, "R10", "no deactivate without hw bit", n_dir, 0);
      chk(done_cyc == act_cyc + 1, "R11", "done after write", done_cyc, act_cyc + 1);
   endtask

   task automatic t_match_hw();
      clear_lrs();
      lrs[1] = mk_lr(16'd77, 10'h155, 8'h80, 1'b0, 1'b1, 1'b1);
      run_eoi(16'd77, 1'b0, 1'b0, 3'd0, 4'd8, 8'h80, 1'b0);
      chk(n_dir == 1, "R10", "deactivate count", n_dir, 1);
      chk(d_pid == 10'h155, "R10", "physical id", d_pid, 10'h155);
      chk(n_lrw == 1 && lrs[1][36] == 1'b0, "R9", "hw entry cleared", lrs[1][36], 0);
   endtask

   task automatic t_first_wins();
      clear_lrs();
      lrs[0] = mk_lr(16'd50, 10'd0, 8'h20, 1'b1, 1'b0, 1'b0);
      lrs[1] = mk_lr(16'd50, 10'd1, 8'h20, 1'b1, 1'b0, 1'b1);
      lrs[3] = mk_lr(16'd50, 10'd3, 8'h20, 1'b1, 1'b0, 1'b1);
      run_eoi(16'd50, 1'b1, 1'b0, 3'd0, 4'd8, 8'h20, 1'b0);
      chk(n_lrw == 1 && w_idx == 3'd1, "R5", "first active match index", w_idx, 1);
      chk(lrs[3][36] == 1'b1, "R5", "later match untouched", lrs[3][36], 1);
   endtask

   task automatic t_used_limit();
      clear_lrs();
      lrs[3] = mk_lr(16'd60, 10'd3, 8'h20, 1'b1, 1'b0, 1'b1);
      hcr_reg = 32'h1000_0001;
      run_eoi(16'd60, 1'b1, 1'b0, 3'd0, 4'd3, 8'h20, 1'b0);
      chk(n_lrw == 0, "R5", "entry above used count ignored", n_lrw, 0);
      chk(n_hcrw == 1 && hcr_reg == 32'h1800_0001, "R6", "counter bump", hcr_reg, 32'h1800_0001);
   endtask

   task automatic t_miss_wrap();
      clear_lrs();
      hcr_reg = 32'hF812_3456;
      run_eoi(16'd99, 1'b1, 1'b0, 3'd0, 4'd8, 8'h20, 1'b0);
      chk(n_hcrw == 1, "R6", "one control write", n_hcrw, 1);
      chk(hcr_reg == 32'h0012_3456, "R6", "wrap keeps other bits", hcr_reg, 32'h0012_3456);
      chk(done_cyc == act_cyc + 1, "R11", "done after counter", done_cyc, act_cyc + 1);
   endtask

   task automatic t_grp_mismatch();
      clear_lrs();
      lrs[0] = mk_lr(16'd70, 10'd5, 8'h40, 1'b0, 1'b1, 1'b1);
      run_eoi(16'd70, 1'b1, 1'b0, 3'd0, 4'd4, 8'h40, 1'b0);
      chk(n_lrw == 0 && n_dir == 0 && n_hcrw == 0, "R7", "no writes on group mismatch",
          n_lrw + n_dir + n_hcrw, 0);
   endtask

   task automatic t_prio();
      clear_lrs();
      lrs[0] = mk_lr(16'd80, 10'd6, 8'h50, 1'b1, 1'b0, 1'b1);
      run_eoi(16'd80, 1'b1, 1'b0, 3'd3, 4'd4, 8'h40, 1'b0);
      chk(n_lrw == 0 && n_hcrw == 0, "R8", "no write on priority mismatch", n_lrw + n_hcrw, 0);
      lrs[0] = mk_lr(16'd80, 10'd6, 8'h47, 1'b1, 1'b0, 1'b1);
      run_eoi(16'd80, 1'b1, 1'b0, 3'd3, 4'd4, 8'h40, 1'b0);
      chk(n_lrw == 1 && w_idx == 3'd0, "R8", "masked bits equal proceeds", n_lrw, 1);
      lrs[0] = mk_lr(16'd80, 10'd6, 8'h47, 1'b1, 1'b0, 1'b1);
      run_eoi(16'd80, 1'b1, 1'b0, 3'd0, 4'd4, 8'h40, 1'b0);
      chk(n_lrw == 0, "R8", "unmasked low bits mismatch", n_lrw, 0);
   endtask

   task automatic t_busy_ignore();
      clear_lrs();
      lrs[0] = mk_lr(16'd9, 10'd7, 8'h40, 1'b1, 1'b0, 1'b1);
      lrs[2] = mk_lr(16'd11, 10'd8, 8'h40, 1'b1, 1'b0, 1'b1);
      run_eoi(16'd11, 1'b1, 1'b0, 3'd0, 4'd4, 8'h40, 1'b1);
      chk(lrs[0][36] == 1'b1, "R11", "strobe while busy ignored", lrs[0][36], 1);
      chk(n_lrw == 1 && w_idx == 3'd2, "R11", "original EOI served", w_idx, 2);
   endtask

   initial begin
      clear_lrs();
      repeat (4) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      t_lpi();
      t_split();
      t_match_basic();
      t_match_hw();
      t_first_wins();
      t_used_limit();
      t_miss_wrap();
      t_grp_mismatch();
      t_prio();
      t_busy_ignore();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule